// File: doc/BRIEF.md
# NOR Flash Embedded-Operation Controller

This block is the command interpreter and self-timed program/erase engine of a byte-wide NOR flash device, written as synthesizable RTL around a small register array. A host drives it through an asynchronous-style parallel bus with active-low chip, write and output enables, an address and a data byte. Writes carry command codes. Reads return array bytes, or a status byte while an operation is running.

Program and erase run in the background. A program clears bits in one byte. An erase walks the array and overwrites every byte of the selected sectors first with zeros and then with ones. While either operation runs, a read returns the complement of the final bit 7, and a bit that flips on each new read. An erase can be held so that sectors outside the erase can be read, and then continued. A hardware mask shields any set of sectors. An active-low reset stops any operation. The array is split into seven bottom-boot sectors of unequal size. One scaling parameter sets the bytes per size unit. Program and erase durations are parameter cycle counts.

Top module: `nor_flash`

## Requirements
- R1: A write is taken only in the first clock cycle where `ceN`=0, `weN`=0 and `oeN`=1. A write held over several cycles counts once. `addr` and `dataIn` are latched in that cycle. When no read is active (`ceN`=0, `oeN`=0, `weN`=1), `dataOut` is 0xFF.
- R2: Writing 0xA0 arms a program. The next write gives the target address and the data byte.
- R3: Programming stores old AND data, so bits only go from 1 to 0. The byte changes, and read mode returns, exactly PROG_CYCLES clock edges after the edge that takes the data write.
- R4: Writing 0x80 and then 0x30 at any address of a sector sets every byte of that sector to 0xFF. No other sector changes. The erase lasts 2·DEPTH·ERASE_CYCLES active edges.
- R5: Writing 0x80 and then 0x10 sets every byte of every unprotected sector to 0xFF, with the same duration. Protected sectors keep their data.
- R6: When `protMask` bit i is 1, sector i is protected. A program or a sector erase aimed at sector i is dropped, and the controller is back in read mode on the next cycle. A chip erase with every sector protected is dropped as well.
- R7: During a program or erase, a read returns {~T, toggle, 000000}. T is bit 7 of the programmed data for a program, and 1 for an erase.
- R8: The toggle bit is 0 after reset. It inverts on each clock edge where a read begins while status is shown.
- R9: 0xB0 during an erase holds it: its progress stops. While held, reads of sectors outside the erase return array data, and reads inside it return status. 0x30 continues the erase. Every other write while held, or while a program or an unsuspended erase runs (except 0xB0), is ignored.
- R10: In read mode, a code other than 0xA0 or 0x80 (0xF0 included) leaves the controller in read mode. A second write after 0x80 other than 0x10 or 0x30 also returns to read mode. The array is unchanged in both cases.
- R11: `rstN`=0 stops any operation at once. A program that has not finished leaves its byte untouched. Read mode and toggle 0 follow.
- R12: Sectors 0..6 run upward from address 0 with sizes 2,1,1,4,8,8,8 units of 2^UNIT_SHIFT bytes. The sector of an address is found from addr >> UNIT_SHIFT.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low reset, stops any operation |
| ceN | input | 1 | Chip enable, active low |
| weN | input | 1 | Write enable, active low |
| oeN | input | 1 | Output enable, active low |
| addr | input | UNIT_SHIFT+5 | Byte address |
| dataIn | input | 8 | Write data / command code |
| dataOut | output | 8 | Read data, status byte, or 0xFF when idle |
| protMask | input | 7 | Per-sector protection, bit i shields sector i |

## Verification
A wrong state register shows up on the first read after the fault, or on the first command write. A stuck busy flag gives status bytes in place of array data. A counter off by one moves the last status read, or the first read of the new data, by a cycle. A wrong erase set changes a byte outside the targeted sector. That byte is seen as soon as it is read back after completion, or during a suspend. A reference model compares `dataOut` on every cycle, so each of these deviations is reported within the cycle it reaches the pins.

// File: rtl/nor_flash_pkg.sv
package nor_flash_pkg;

  localparam int NUM_SECT = 7;

  localparam logic [7:0] CMD_PROG    = 8'hA0;
  localparam logic [7:0] CMD_ERASE   = 8'h80;
  localparam logic [7:0] CMD_SECTOR  = 8'h30;
  localparam logic [7:0] CMD_CHIP    = 8'h10;
  localparam logic [7:0] CMD_SUSPEND = 8'hB0;
  localparam logic [7:0] CMD_RESUME  = 8'h30;

  typedef enum logic [2:0] {
    ST_READ, ST_PSETUP, ST_ESETUP, ST_PROG, ST_ERASE, ST_SUSP
  } ctrlState_t;

  // strobes from control to datapath
  typedef struct packed {
    logic                memWe;
    logic                opSet;
    logic [7:0]          memData;
    logic                busy;
    logic                suspended;
    logic                dq7Target;
    logic [NUM_SECT-1:0] eraseSet;
  } ctrlStrobe_t;

  // bottom-boot map, in units: 2,1,1,4,8,8,8
  function automatic logic [2:0] sectorOfUnit(input logic [4:0] unitIdx);
    if (unitIdx < 5'd2)       return 3'd0;
    else if (unitIdx < 5'd3)  return 3'd1;
    else if (unitIdx < 5'd4)  return 3'd2;
    else if (unitIdx < 5'd8)  return 3'd3;
    else if (unitIdx < 5'd16) return 3'd4;
    else if (unitIdx < 5'd24) return 3'd5;
    else                      return 3'd6;
  endfunction

endpackage

// File: rtl/nor_flash_ctrl.sv
module nor_flash_ctrl
  import nor_flash_pkg::*;
#(
  parameter int UNIT_SHIFT   = 2,
  parameter int PROG_CYCLES  = 8,
  parameter int ERASE_CYCLES = 2
) (
  input  logic                  clk,
  input  logic                  rstN,
  input  logic                  cmdStb,
  input  logic [UNIT_SHIFT+4:0] cmdAddr,
  input  logic [7:0]            cmdData,
  input  logic [NUM_SECT-1:0]   protMask,
  output ctrlStrobe_t           str,
  output logic [UNIT_SHIFT+4:0] memAddr
);
  localparam int AW      = UNIT_SHIFT + 5;
  localparam int CNT_MAX = (PROG_CYCLES > ERASE_CYCLES) ? PROG_CYCLES : ERASE_CYCLES;
  localparam int CNT_W   = $clog2(CNT_MAX + 1);
  localparam logic [AW-1:0]    LAST_ADDR = '1;
  localparam logic [CNT_W-1:0] PROG_LOAD = CNT_W'(PROG_CYCLES - 1);
  localparam logic [CNT_W-1:0] ERASE_LOAD = CNT_W'(ERASE_CYCLES - 1);

  ctrlState_t          state;
  logic [AW-1:0]       tgtAddr;
  logic [7:0]          tgtData;
  logic [CNT_W-1:0]    waitCnt;
  logic [AW-1:0]       walkAddr;
  logic                passOnes;
  logic [NUM_SECT-1:0] eraseSet;
  logic [2:0]          cmdSect;
  logic [2:0]          walkSect;
  logic                suspReq;
  logic                stepNow;
  logic                progDone;

  assign cmdSect  = sectorOfUnit(cmdAddr[AW-1:UNIT_SHIFT]);
  assign walkSect = sectorOfUnit(walkAddr[AW-1:UNIT_SHIFT]);
  assign suspReq  = cmdStb && (cmdData == CMD_SUSPEND);
  assign stepNow  = (state == ST_ERASE) && !suspReq && (waitCnt == '0);
  assign progDone = (state == ST_PROG) && (waitCnt == '0);

  always_comb begin
    str.memWe     = progDone || (stepNow && eraseSet[walkSect]);
    str.opSet     = (state == ST_ERASE) && passOnes;
    str.memData   = (state == ST_PROG) ? tgtData : 8'h00;
    str.busy      = (state == ST_PROG) || (state == ST_ERASE);
    str.suspended = (state == ST_SUSP);
    str.dq7Target = (state == ST_PROG) ? tgtData[7] : 1'b1;
    str.eraseSet  = eraseSet;
    memAddr       = (state == ST_PROG) ? tgtAddr : walkAddr;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state    <= ST_READ;
      tgtAddr  <= '0;
      tgtData  <= '0;
      waitCnt  <= '0;
      walkAddr <= '0;
      passOnes <= 1'b0;
      eraseSet <= '0;
    end else begin
      case (state)
        ST_READ: if (cmdStb) begin
          if (cmdData == CMD_PROG)       state <= ST_PSETUP;
          else if (cmdData == CMD_ERASE) state <= ST_ESETUP;
        end
        ST_PSETUP: if (cmdStb) begin
          if (protMask[cmdSect]) state <= ST_READ;
          else begin
            tgtAddr <= cmdAddr;
            tgtData <= cmdData;
            waitCnt <= PROG_LOAD;
            state   <= ST_PROG;
          end
        end
        ST_ESETUP: if (cmdStb) begin
          walkAddr <= '0;
          passOnes <= 1'b0;
          waitCnt  <= ERASE_LOAD;
          if (cmdData == CMD_SECTOR && !protMask[cmdSect]) begin
            eraseSet <= NUM_SECT'(1) << cmdSect;
            state    <= ST_ERASE;
          end else if (cmdData == CMD_CHIP && (~protMask) != '0) begin
            eraseSet <= ~protMask;
            state    <= ST_ERASE;
          end else begin
            state    <= ST_READ;
          end
        end
        ST_PROG: begin
          if (waitCnt == '0) state <= ST_READ;
          else               waitCnt <= waitCnt - 1'b1;
        end
        ST_ERASE: begin
          if (suspReq) state <= ST_SUSP;
          else if (waitCnt == '0) begin
            waitCnt <= ERASE_LOAD;
            if (walkAddr == LAST_ADDR) begin
              walkAddr <= '0;
              if (passOnes) begin
                passOnes <= 1'b0;
                eraseSet <= '0;
                state    <= ST_READ;
              end else begin
                passOnes <= 1'b1;
              end
            end else begin
              walkAddr <= walkAddr + 1'b1;
            end
          end else begin
            waitCnt <= waitCnt - 1'b1;
          end
        end
        ST_SUSP: if (cmdStb && cmdData == CMD_RESUME) state <= ST_ERASE;
        default: state <= ST_READ;
      endcase
    end
  end

  // R6
  prot_skip_chk: assert property (@(posedge clk) disable iff (!rstN)
    (state == ST_ESETUP && cmdStb) |=> ((eraseSet & $past(protMask)) == '0));

  // R6
  prot_prog_chk: assert property (@(posedge clk) disable iff (!rstN)
    (state == ST_PSETUP && cmdStb && protMask[cmdSect]) |=> (state == ST_READ));

  // R9
  susp_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    (state == ST_SUSP && !(cmdStb && cmdData == CMD_RESUME))
      |=> (state == ST_SUSP && $stable(walkAddr) && $stable(waitCnt)));

  // R3
  prog_exit_chk: assert property (@(posedge clk) disable iff (!rstN)
    (state == ST_PROG) |=> (state == ST_PROG || state == ST_READ));

  // R10
  bad_code_chk: assert property (@(posedge clk) disable iff (!rstN)
    (state == ST_READ && cmdStb && cmdData != CMD_PROG && cmdData != CMD_ERASE)
      |=> (state == ST_READ));

  // R4
  erase_set_chk: assert property (@(posedge clk) disable iff (!rstN)
    (state == ST_ERASE) |-> (eraseSet != '0));

endmodule

// File: rtl/nor_flash_array.sv
module nor_flash_array
  import nor_flash_pkg::*;
#(
  parameter int UNIT_SHIFT = 2
) (
  input  logic                  clk,
  input  logic                  rstN,
  input  logic                  ceN,
  input  logic                  weN,
  input  logic                  oeN,
  input  logic [UNIT_SHIFT+4:0] addr,
  output logic [7:0]            dataOut,
  input  ctrlStrobe_t           str,
  input  logic [UNIT_SHIFT+4:0] memAddr,
  output logic                  cmdStb
);
  localparam int AW    = UNIT_SHIFT + 5;
  localparam int DEPTH = 1 << AW;

  logic [7:0] mem [DEPTH];
  logic       wrCond, rdCond, wrPrev, rdPrev, toggleQ;
  logic       statusView;
  logic [2:0] addrSect;

  assign wrCond     = !ceN && !weN && oeN;
  assign rdCond     = !ceN && !oeN && weN;
  assign cmdStb     = wrCond && !wrPrev;
  assign addrSect   = sectorOfUnit(addr[AW-1:UNIT_SHIFT]);
  assign statusView = str.busy || (str.suspended && str.eraseSet[addrSect]);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      wrPrev  <= 1'b0;
      rdPrev  <= 1'b0;
      toggleQ <= 1'b0;
    end else begin
      wrPrev <= wrCond;
      rdPrev <= rdCond;
      if (rdCond && !rdPrev && statusView) toggleQ <= ~toggleQ;
    end
  end

  always_ff @(posedge clk) begin
    if (str.memWe)
      mem[memAddr] <= str.opSet ? 8'hFF : (mem[memAddr] & str.memData);
  end

  always_comb begin
    if (!rdCond)         dataOut = 8'hFF;
    else if (statusView) dataOut = {~str.dq7Target, toggleQ, 6'b0};
    else                 dataOut = mem[addr];
  end

  // R1
  one_stb_chk: assert property (@(posedge clk) disable iff (!rstN)
    cmdStb |=> !cmdStb);

endmodule

// File: rtl/nor_flash.sv
module nor_flash
  import nor_flash_pkg::*;
#(
  parameter int UNIT_SHIFT   = 2,
  parameter int PROG_CYCLES  = 8,
  parameter int ERASE_CYCLES = 2
) (
  input  logic                  clk,
  input  logic                  rstN,
  input  logic                  ceN,
  input  logic                  weN,
  input  logic                  oeN,
  input  logic [UNIT_SHIFT+4:0] addr,
  input  logic [7:0]            dataIn,
  output logic [7:0]            dataOut,
  input  logic [6:0]            protMask
);
  ctrlStrobe_t           str;
  logic [UNIT_SHIFT+4:0] memAddr;
  logic                  cmdStb;

  nor_flash_ctrl #(
    .UNIT_SHIFT(UNIT_SHIFT), .PROG_CYCLES(PROG_CYCLES), .ERASE_CYCLES(ERASE_CYCLES)
  ) u_ctrl (
    .clk(clk), .rstN(rstN), .cmdStb(cmdStb), .cmdAddr(addr), .cmdData(dataIn),
    .protMask(protMask), .str(str), .memAddr(memAddr)
  );

  nor_flash_array #(.UNIT_SHIFT(UNIT_SHIFT)) u_array (
    .clk(clk), .rstN(rstN), .ceN(ceN), .weN(weN), .oeN(oeN), .addr(addr),
    .dataOut(dataOut), .str(str), .memAddr(memAddr), .cmdStb(cmdStb)
  );

endmodule

// File: tb/nor_flash_test.sv
module nor_flash_test;
  localparam int CLK_PERIOD = 10;
  localparam int US    = 2;
  localparam int UNITB = 1 << US;
  localparam int DEPTH = 32 * UNITB;
  localparam int PC    = 5;
  localparam int EC    = 2;
  localparam int WATCHDOG = 100000;

  logic       clk = 0;
  logic       rstN, ceN, weN, oeN;
  logic [6:0] addr;
  logic [7:0] dataIn;
  logic [6:0] protMask;
  wire  [7:0] dataOut;

  nor_flash #(.UNIT_SHIFT(US), .PROG_CYCLES(PC), .ERASE_CYCLES(EC)) uut (
    .clk(clk), .rstN(rstN), .ceN(ceN), .weN(weN), .oeN(oeN), .addr(addr),
    .dataIn(dataIn), .dataOut(dataOut), .protMask(protMask)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  int total = 0, bad = 0, cyc = 0;
  string curReq = "R1";
  bit cmpOn = 0;

  // reference model: 0 read, 1 prog armed, 2 erase armed, 3 programming, 4 erasing, 5 held
  int mState = 0, mLeft = 0, mPAddr = 0;
  logic [7:0] mPData;
  logic [7:0] mMem [DEPTH];
  bit   mKnown [DEPTH];
  logic [6:0] mSet = '0;
  bit mTog = 0, mRdPrev = 0, mWrPrev = 0;
  bit mRd, mWr, mWs, mSv;
  int mS;

  function automatic int sectOf(int a);
    int base = 0;
    for (int i = 0; i < 7; i++) begin
      int sz = (i == 0) ? 2 : (i < 3) ? 1 : (i == 3) ? 4 : 8;
      base += sz * UNITB;
      if (a < base) return i;
    end
    return 6;
  endfunction

  function automatic bit modelStatus(int a);
    return (mState == 3) || (mState == 4) || (mState == 5 && mSet[sectOf(a)]);
  endfunction

  always @(posedge clk) begin
    if (!rstN) begin
      if (mState == 4 || mState == 5)
        for (int a = 0; a < DEPTH; a++) if (mSet[sectOf(a)]) mKnown[a] = 0;
      mState = 0; mTog = 0; mRdPrev = 0; mWrPrev = 0; mSet = '0;
    end else begin
      mRd = !ceN && !oeN && weN;
      mWr = !ceN && !weN && oeN;
      mWs = mWr && !mWrPrev;
      mSv = modelStatus(int'(addr));
      if (mRd && !mRdPrev && mSv) mTog = !mTog;
      mRdPrev = mRd; mWrPrev = mWr;
      mS = sectOf(int'(addr));
      case (mState)
        0: if (mWs) mState = (dataIn == 8'hA0) ? 1 : (dataIn == 8'h80) ? 2 : 0;
        1: if (mWs) begin
             if (protMask[mS]) mState = 0;
             else begin mPAddr = int'(addr); mPData = dataIn; mLeft = PC; mState = 3; end
           end
        2: if (mWs) begin
             if (dataIn == 8'h30 && !protMask[mS]) begin
               mSet = '0; mSet[mS] = 1; mLeft = 2 * DEPTH * EC; mState = 4;
             end else if (dataIn == 8'h10 && protMask != 7'h7F) begin
               mSet = ~protMask; mLeft = 2 * DEPTH * EC; mState = 4;
             end else mState = 0;
           end
        3: begin
             mLeft--;
             if (mLeft == 0) begin mMem[mPAddr] = mMem[mPAddr] & mPData; mState = 0; end
           end
        4: if (mWs && dataIn == 8'hB0) mState = 5;
           else begin
             mLeft--;
             if (mLeft == 0) begin
               for (int a = 0; a < DEPTH; a++)
                 if (mSet[sectOf(a)]) begin mMem[a] = 8'hFF; mKnown[a] = 1; end
               mSet = '0; mState = 0;
             end
           end
        5: if (mWs && dataIn == 8'h30) mState = 4;
        default: mState = 0;
      endcase
    end
  end

  // per-cycle comparison against the model, before inputs move
  always @(negedge clk) begin
    if (cmpOn) begin
      logic [7:0] expV;
      bit ok;
      ok = 1;
      if (!(!ceN && !oeN && weN)) expV = 8'hFF;
      else if (modelStatus(int'(addr)))
        expV = {~((mState == 3) ? mPData[7] : 1'b1), mTog, 6'b0};
      else if (mKnown[addr]) expV = mMem[addr];
      else ok = 0;
      if (ok) begin
        total++;
        if (dataOut !== expV) begin
          bad++;
          $display("FAIL %s per-cycle addr=%0d actual=%02h expected=%02h", curReq, addr, dataOut, expV);
        end
      end
    end
  end

  always @(posedge clk) begin
    cyc++;
    if (cyc == WATCHDOG) begin
      bad++;
      $display("FAIL watchdog (all requirements) actual=%0d cycles expected<%0d", cyc, WATCHDOG);
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  task automatic chk(input string req, input logic [7:0] got, input logic [7:0] exp);
    total++;
    if (got !== exp) begin
      bad++;
      $display("FAIL %s actual=%02h expected=%02h", req, got, exp);
    end
  endtask

  task automatic busWrite(input logic [6:0] a, input logic [7:0] d);
    @(negedge clk); #1 ceN = 0; weN = 0; oeN = 1; addr = a; dataIn = d;
    @(negedge clk); #1 weN = 1; ceN = 1;
  endtask

  task automatic busRead(input logic [6:0] a, input logic [7:0] mask,
                         input logic [7:0] exp, input string req);
    @(negedge clk); #1 ceN = 0; oeN = 0; weN = 1; addr = a;
    @(negedge clk); chk(req, dataOut & mask, exp);
    #1 ceN = 1; oeN = 1;
  endtask

  task automatic waitReady();
    while (mState != 0) @(negedge clk);
  endtask

  task automatic progByte(input logic [6:0] a, input logic [7:0] d);
    busWrite(7'd0, 8'hA0); busWrite(a, d); waitReady();
  endtask

  initial begin
    rstN = 0; ceN = 1; weN = 1; oeN = 1; addr = '0; dataIn = '0; protMask = '0;
    for (int a = 0; a < DEPTH; a++) mKnown[a] = 0;
    repeat (3) @(negedge clk);
    cmpOn = 1;
    #1 rstN = 1;
    @(negedge clk);
    chk("R11 idle after reset", dataOut, 8'hFF); // R1 idle output

    // R5: chip erase with nothing protected gives a known all-ones array
    curReq = "R5";
    busWrite(7'd0, 8'h80); busWrite(7'd0, 8'h10); waitReady();
    busRead(7'd0, 8'hFF, 8'hFF, "R5 erased byte 0");
    busRead(7'd127, 8'hFF, 8'hFF, "R5 erased byte 127");

    // R7 / R8: status during a program, toggle inverts per read
    curReq = "R7";
    busWrite(7'd0, 8'hA0); busWrite(7'd5, 8'hA5);
    busRead(7'd5, 8'hFF, 8'h40, "R7 R8 first status read");
    busRead(7'd5, 8'hFF, 8'h00, "R8 second status read");
    waitReady();
    busRead(7'd5, 8'hFF, 8'hA5, "R2 programmed value");

    // R3: bits only clear, DQ7 follows data bit 7
    curReq = "R3";
    busWrite(7'd0, 8'hA0); busWrite(7'd5, 8'h3C);
    busRead(7'd5, 8'h80, 8'h80, "R7 dq7 for data bit7=0");
    waitReady();
    busRead(7'd5, 8'hFF, 8'h24, "R3 old AND new");

    // R12: bytes on both sides of sector edges
    curReq = "R12";
    progByte(7'd7, 8'h00);  progByte(7'd8, 8'h00);  progByte(7'd12, 8'h00);
    progByte(7'd16, 8'h00); progByte(7'd31, 8'h00); progByte(7'd32, 8'h00);
    progByte(7'd127, 8'h00);

    // R4: erase sector 1 only
    curReq = "R4";
    busWrite(7'd10, 8'h80); busWrite(7'd10, 8'h30);
    busRead(7'd8, 8'hBF, 8'h00, "R7 erase status dq7=0");
    waitReady();
    busRead(7'd8, 8'hFF, 8'hFF, "R4 sector1 erased");
    busRead(7'd7, 8'hFF, 8'h00, "R12 sector0 last byte kept");
    busRead(7'd12, 8'hFF, 8'h00, "R12 sector2 first byte kept");

    // R6: protection of sector 3
    curReq = "R6";
    protMask = 7'b0001000;
    busWrite(7'd0, 8'hA0); busWrite(7'd20, 8'h00);
    busRead(7'd20, 8'hFF, 8'hFF, "R6 protected program dropped, no status");
    busWrite(7'd0, 8'h80); busWrite(7'd16, 8'h30);
    busRead(7'd16, 8'hFF, 8'h00, "R6 protected erase dropped");
    curReq = "R5";
    busWrite(7'd0, 8'h80); busWrite(7'd0, 8'h10); waitReady();
    busRead(7'd16, 8'hFF, 8'h00, "R5 protected sector kept");
    busRead(7'd31, 8'hFF, 8'h00, "R5 protected sector kept end");
    busRead(7'd7, 8'hFF, 8'hFF, "R5 unprotected erased");
    busRead(7'd127, 8'hFF, 8'hFF, "R5 last sector erased");
    protMask = '0;

    // R9: suspend an erase of sector 4
    curReq = "R9";
    progByte(7'd5, 8'h0F);
    busWrite(7'd40, 8'h80); busWrite(7'd40, 8'h30);
    repeat (20) @(negedge clk);
    busWrite(7'd0, 8'hB0);
    busRead(7'd5, 8'hFF, 8'h0F, "R9 read outside erase while held");
    busRead(7'd40, 8'hBF, 8'h00, "R9 status inside erase while held");
    busWrite(7'd0, 8'hA0); busWrite(7'd6, 8'h00);
    busRead(7'd6, 8'hFF, 8'hFF, "R9 program ignored while held");
    repeat (600) @(negedge clk);
    busRead(7'd40, 8'hBF, 8'h00, "R9 erase still held");
    busWrite(7'd0, 8'h30); waitReady();
    busRead(7'd40, 8'hFF, 8'hFF, "R9 resumed erase completes");
    busRead(7'd5, 8'hFF, 8'h0F, "R9 other sector intact");

    // R10: unknown codes
    curReq = "R10";
    busWrite(7'd0, 8'h55);
    busRead(7'd5, 8'hFF, 8'h0F, "R10 unknown code to read mode");
    busWrite(7'd0, 8'h80); busWrite(7'd5, 8'h77);
    busRead(7'd5, 8'hFF, 8'h0F, "R10 bad erase second write");
    busWrite(7'd0, 8'hF0);
    busRead(7'd5, 8'hFF, 8'h0F, "R10 0xF0 read mode");

    // R1: held write counts once; write with oeN low is not taken
    curReq = "R1";
    @(negedge clk); #1 ceN = 0; weN = 0; oeN = 1; addr = 7'd0; dataIn = 8'hA0;
    repeat (3) @(negedge clk); #1 weN = 1; ceN = 1;
    busWrite(7'd50, 8'h0F); waitReady();
    busRead(7'd50, 8'hFF, 8'h0F, "R1 held write counted once");
    @(negedge clk); #1 ceN = 0; weN = 0; oeN = 0; addr = 7'd0; dataIn = 8'hA0;
    @(negedge clk); #1 weN = 1; ceN = 1; oeN = 1;
    busWrite(7'd51, 8'h00); waitReady();
    busRead(7'd51, 8'hFF, 8'hFF, "R1 write with oeN low ignored");

    // R11: reset during a program
    curReq = "R11";
    busWrite(7'd0, 8'hA0); busWrite(7'd0, 8'h00);
    @(negedge clk); #1 rstN = 0;
    repeat (2) @(negedge clk); #1 rstN = 1;
    @(negedge clk);
    chk("R11 idle output after reset", dataOut, 8'hFF);
    busRead(7'd0, 8'hFF, 8'hFF, "R11 aborted program leaves byte");

    repeat (2) @(negedge clk);
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule